// File: doc/BRIEF.md
# Twin-Predicated Vector Element Sequencer

This block walks a vector operation one element at a time and tells the datapath which source element to read and which destination element to write. The source side and the destination side each have their own predicate mask. Each side also has its own choice of what a cleared mask bit means. In zeroing mode the slot is still visited and carries a zero. In skip mode the slot is passed over, so nothing is read from it or written to it. Because the two sides use their own rules, the source index and the destination index move independently. Skipping on the source packs the active source elements together. Skipping on the destination spreads the results across the active destination slots. With both set, a compress followed by an expand is done in a single pass, for any operation.

Each emitted step uses a valid/ready handshake toward the datapath. Along with each step the block drives a byte-granular write strobe and a row number for a register file whose rows are wider than the elements. A narrow element can then be written without disturbing its neighbours and without a read-modify-write. The operation ends as soon as either side runs out of usable slots. A one-cycle completion pulse marks the end, and the sequencer then goes back to idle.

Top module: `tpseq_top`

## Requirements
- R1: After reset, `busy`, `step_valid`, `done` and `wr_strb` are all low.
- R2: A `start` pulse while idle captures `vl`, both masks, both mode bits and `elem_w`, and begins a run with both indices at 0. A `start` pulse while `busy` is high has no effect on the running sequence.
- R3: With `src_zero_mode`=1, every source index from 0 to vl-1 is presented in ascending order. `src_use_zero` is 1 exactly when `src_mask` bit [index] is 0.
- R4: With `src_zero_mode`=0 (skip), only indices whose `src_mask` bit is 1 are presented, in ascending order, and `src_use_zero` stays 0.
- R5: With `dst_zero_mode`=1, every destination index from 0 to vl-1 is presented in ascending order with `dst_we`=1. `dst_write_zero` is 1 exactly when `dst_mask` bit [index] is 0.
- R6: With `dst_zero_mode`=0 (skip), only indices whose `dst_mask` bit is 1 are presented, and `dst_write_zero` stays 0. Cleared slots are never written.
- R7: The k-th source slot is paired with the k-th destination slot. The two indices drift apart whenever the two sides visit different sets of slots, even when both masks are equal.
- R8: The indices advance only on a cycle where `step_valid` and `step_ready` are both 1. While the step is stalled, all step outputs hold steady.
- R9: When either side has no slot left below vl, `done` pulses high for one cycle with `step_valid` low, and the block then becomes idle. If vl=0, or if a side in skip mode has no set mask bit below vl, `done` comes in the first run cycle and no step is emitted.
- R10: A `vl` larger than MAXVL is treated as MAXVL.
- R11: `elem_w` selects the element size: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit, 3 is 64-bit. Let bpe be the bytes per element and epr = (ROW_W/8)/bpe. Then `wr_row` = dst_idx / epr, and `wr_strb` byte b is set exactly when b / bpe equals dst_idx mod epr. `wr_strb` is zero whenever `step_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new operation (taken only when idle) |
| vl | input | IDXW | Vector length |
| src_mask | input | MAXVL | Source predicate, bit i for element i |
| dst_mask | input | MAXVL | Destination predicate, bit i for element i |
| src_zero_mode | input | 1 | 1: zero masked source slots, 0: skip them |
| dst_zero_mode | input | 1 | 1: write zero to masked destination slots, 0: skip them |
| elem_w | input | 2 | Element width code |
| busy | output | 1 | A run is in progress |
| step_valid | output | 1 | A step is offered to the datapath |
| step_ready | input | 1 | Datapath accepts the step |
| src_idx | output | IDXW | Source element index |
| src_use_zero | output | 1 | Use zero in place of the source element |
| dst_idx | output | IDXW | Destination element index |
| dst_we | output | 1 | Destination write enable |
| dst_write_zero | output | 1 | Write zero rather than the result |
| wr_row | output | IDXW | Register-file row holding the destination element |
| wr_strb | output | ROW_W/8 | Byte write strobes within the row |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
The bench drives runs with matched masks and mixed modes. In those runs a design that advanced both indices together would keep them in lockstep and pair results with the wrong slots. Runs with vl=0, with an empty mask in skip mode, and with an oversize vl test termination. A sequencer that ended one step late, ignored the clamp, or emitted a stray step before finishing would show up here. An irregular ready pattern exposes indices that advance without a handshake. A restart pulse during a run catches a design that reloads its configuration while busy. Every element width is covered, so strobe or row arithmetic that mixes up lane and row would write the wrong bytes.

// File: rtl/tpseq_pkg.sv
package tpseq_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  localparam int EW_CODE_W = 2;
endpackage

// File: rtl/tpseq_rst_sync.sv
module tpseq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/tpseq_scan.sv
// Finds the next slot a side will visit at or above `from`, below `lim`.
module tpseq_scan #(
  parameter int N  = 8,
  parameter int IW = 4
) (
  input  logic [N-1:0]  mask,
  input  logic [IW-1:0] from,
  input  logic [IW-1:0] lim,
  input  logic          zmode,
  output logic [IW-1:0] pos,
  output logic          live,
  output logic          bit_at
);
  always_comb begin
    pos    = lim;
    live   = 1'b0;
    bit_at = 1'b0;
    if (zmode) begin
      if (from < lim) begin
        pos  = from;
        live = 1'b1;
        for (int i = 0; i < N; i++) begin
          if (IW'(i) == from) bit_at = mask[i];
        end
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (!live && (IW'(i) >= from) && (IW'(i) < lim) && mask[i]) begin
          pos    = IW'(i);
          live   = 1'b1;
          bit_at = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tpseq_lanes.sv
// Maps a destination element index to a row number and byte strobes.
module tpseq_lanes #(
  parameter int NB = 8,
  parameter int IW = 4
) (
  input  logic [IW-1:0] idx,
  input  logic [1:0]    ew,
  input  logic          en,
  output logic [IW-1:0] row,
  output logic [NB-1:0] strb
);
  localparam int LNB = $clog2(NB);

  int unsigned    shift;
  logic [IW-1:0]  lane;

  always_comb begin
    shift = LNB - int'(ew);
    lane  = idx & ((IW'(1) << shift) - IW'(1));
    row   = idx >> shift;
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign strb[b] = en && (IW'(b >> ew) == lane);
  end
endmodule

// File: rtl/tpseq_top.sv
module tpseq_top #(
  parameter int MAXVL = 8,
  parameter int ROW_W = 64,
  parameter int IDXW  = $clog2(MAXVL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [IDXW-1:0]    vl,
  input  logic [MAXVL-1:0]   src_mask,
  input  logic [MAXVL-1:0]   dst_mask,
  input  logic               src_zero_mode,
  input  logic               dst_zero_mode,
  input  logic [1:0]         elem_w,
  output logic               busy,
  output logic               step_valid,
  input  logic               step_ready,
  output logic [IDXW-1:0]    src_idx,
  output logic               src_use_zero,
  output logic [IDXW-1:0]    dst_idx,
  output logic               dst_we,
  output logic               dst_write_zero,
  output logic [IDXW-1:0]    wr_row,
  output logic [ROW_W/8-1:0] wr_strb,
  output logic               done
);
  import tpseq_pkg::*;

  localparam int NB = ROW_W / 8;
  localparam logic [IDXW-1:0] VL_CAP = IDXW'(MAXVL);

  logic rst_n_s;

  seq_state_e       state_q, state_d;
  logic [IDXW-1:0]  vl_q, vl_d;
  logic [MAXVL-1:0] smask_q, smask_d, dmask_q, dmask_d;
  logic             szero_q, szero_d, dzero_q, dzero_d;
  logic [1:0]       ew_q, ew_d;
  logic [IDXW-1:0]  si_q, si_d, di_q, di_d;

  logic [IDXW-1:0]  s_pos, d_pos;
  logic             s_live, d_live, s_bit, d_bit;
  logic             running, finish, fire, load_cfg, idx_en;

  tpseq_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_n_s)
  );

  tpseq_scan #(.N(MAXVL), .IW(IDXW)) u_src_scan (
    .mask   (smask_q),
    .from   (si_q),
    .lim    (vl_q),
    .zmode  (szero_q),
    .pos    (s_pos),
    .live   (s_live),
    .bit_at (s_bit)
  );

  tpseq_scan #(.N(MAXVL), .IW(IDXW)) u_dst_scan (
    .mask   (dmask_q),
    .from   (di_q),
    .lim    (vl_q),
    .zmode  (dzero_q),
    .pos    (d_pos),
    .live   (d_live),
    .bit_at (d_bit)
  );

  assign running    = (state_q == ST_RUN);
  assign step_valid = running && s_live && d_live;
  assign finish     = running && !(s_live && d_live);
  assign fire       = step_valid && step_ready;
  assign load_cfg   = (state_q == ST_IDLE) && start;
  assign idx_en     = load_cfg || fire;

  // next-state logic
  always_comb begin
    state_d = state_q;
    vl_d    = (vl > VL_CAP) ? VL_CAP : vl;
    smask_d = src_mask;
    dmask_d = dst_mask;
    szero_d = src_zero_mode;
    dzero_d = dst_zero_mode;
    ew_d    = elem_w;
    si_d    = s_pos + IDXW'(1);
    di_d    = d_pos + IDXW'(1);
    if (load_cfg) begin
      state_d = ST_RUN;
      si_d    = '0;
      di_d    = '0;
    end else if (finish) begin
      state_d = ST_IDLE;
    end
  end

  // state register
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  // configuration registers, enabled on an accepted start
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      vl_q    <= '0;
      smask_q <= '0;
      dmask_q <= '0;
      szero_q <= 1'b0;
      dzero_q <= 1'b0;
      ew_q    <= '0;
    end else if (load_cfg) begin
      vl_q    <= vl_d;
      smask_q <= smask_d;
      dmask_q <= dmask_d;
      szero_q <= szero_d;
      dzero_q <= dzero_d;
      ew_q    <= ew_d;
    end
  end

  // element indices, enabled on start or handshake
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      si_q <= '0;
      di_q <= '0;
    end else if (idx_en) begin
      si_q <= si_d;
      di_q <= di_d;
    end
  end

  tpseq_lanes #(.NB(NB), .IW(IDXW)) u_lanes (
    .idx  (d_pos),
    .ew   (ew_q),
    .en   (step_valid),
    .row  (wr_row),
    .strb (wr_strb)
  );

  assign busy           = running;
  assign done           = finish;
  assign src_idx        = s_pos;
  assign dst_idx        = d_pos;
  assign src_use_zero   = step_valid && !s_bit;
  assign dst_we         = step_valid;
  assign dst_write_zero = step_valid && !d_bit;
endmodule

// File: rtl/tpseq_chk.sv
module tpseq_chk #(
  parameter int MAXVL = 8,
  parameter int IW    = 4,
  parameter int NB    = 8
) (
  input logic          clk,
  input logic          rst_n_s,
  input logic          busy,
  input logic          start,
  input logic          step_valid,
  input logic          step_ready,
  input logic [IW-1:0] src_idx,
  input logic [IW-1:0] dst_idx,
  input logic          src_use_zero,
  input logic          dst_write_zero,
  input logic          szero_q,
  input logic          dzero_q,
  input logic [IW-1:0] vl_q,
  input logic [NB-1:0] wr_strb,
  input logic          done
);
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n_s) |-> !busy && !step_valid && !done);

  a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy && start && !done |=> busy && $stable(vl_q));

  a_r4_skip_src_no_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    step_valid && !szero_q |-> !src_use_zero);

  a_r6_skip_dst_no_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    step_valid && !dzero_q |-> !dst_write_zero);

  a_r7_indices_ascend: assert property (@(posedge clk) disable iff (!rst_n_s)
    step_valid && step_ready |=> !step_valid ||
      (src_idx > $past(src_idx) && dst_idx > $past(dst_idx)));

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n_s)
    step_valid && !step_ready |=> step_valid && $stable(src_idx) &&
      $stable(dst_idx) && $stable(src_use_zero) && $stable(dst_write_zero));

  a_r9_done_alone: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> !step_valid);

  a_r9_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !busy && !done);

  a_r10_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n_s)
    step_valid |-> (src_idx < vl_q) && (dst_idx < vl_q) && (vl_q <= MAXVL));

  a_r11_strobe_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    !step_valid |-> wr_strb == '0);

  a_r11_strobe_live: assert property (@(posedge clk) disable iff (!rst_n_s)
    step_valid |-> wr_strb != '0);
endmodule

bind tpseq_top tpseq_chk #(.MAXVL(MAXVL), .IW(IDXW), .NB(ROW_W/8)) u_chk (
  .clk            (clk),
  .rst_n_s        (rst_n_s),
  .busy           (busy),
  .start          (start),
  .step_valid     (step_valid),
  .step_ready     (step_ready),
  .src_idx        (src_idx),
  .dst_idx        (dst_idx),
  .src_use_zero   (src_use_zero),
  .dst_write_zero (dst_write_zero),
  .szero_q        (szero_q),
  .dzero_q        (dzero_q),
  .vl_q           (vl_q),
  .wr_strb        (wr_strb),
  .done           (done)
);

// File: tb/tb_tpseq_top.sv
module tb_tpseq_top;
  localparam int MAXVL = 8;
  localparam int ROW_W = 64;
  localparam int IDXW  = 4;
  localparam int NB    = ROW_W / 8;

  logic             clk;
  logic             rst_n;
  logic             start;
  logic [IDXW-1:0]  vl;
  logic [MAXVL-1:0] src_mask, dst_mask;
  logic             src_zero_mode, dst_zero_mode;
  logic [1:0]       elem_w;
  logic             busy, step_valid, step_ready;
  logic [IDXW-1:0]  src_idx, dst_idx, wr_row;
  logic             src_use_zero, dst_we, dst_write_zero, done;
  logic [NB-1:0]    wr_strb;

  tpseq_top #(.MAXVL(MAXVL), .ROW_W(ROW_W), .IDXW(IDXW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
    .src_mask(src_mask), .dst_mask(dst_mask),
    .src_zero_mode(src_zero_mode), .dst_zero_mode(dst_zero_mode),
    .elem_w(elem_w), .busy(busy), .step_valid(step_valid),
    .step_ready(step_ready), .src_idx(src_idx), .src_use_zero(src_use_zero),
    .dst_idx(dst_idx), .dst_we(dst_we), .dst_write_zero(dst_write_zero),
    .wr_row(wr_row), .wr_strb(wr_strb), .done(done)
  );

  typedef struct {
    int         s;
    bit         sz;
    int         d;
    bit         wz;
    logic [7:0] strb;
    int         row;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    fails  = 0;
  int    done_cnt = 0;
  bit    rdy_rand = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  string tag = "R1";

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ready driver
  initial begin
    step_ready = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step_ready = rdy_rand ? lfsr[0] : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && step_valid && step_ready) begin
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL %s unexpected step src=%0d dst=%0d expected none", tag, src_idx, dst_idx);
        end else begin
          item_t e;
          e = q.pop_front();
          if (int'(src_idx) != e.s || src_use_zero != e.sz || int'(dst_idx) != e.d ||
              dst_write_zero != e.wz || !dst_we || wr_strb != e.strb || int'(wr_row) != e.row) begin
            fails++;
            $display("FAIL %s step actual s=%0d sz=%0b d=%0d wz=%0b we=%0b strb=%h row=%0d expected s=%0d sz=%0b d=%0d wz=%0b we=1 strb=%h row=%0d",
                     tag, src_idx, src_use_zero, dst_idx, dst_write_zero, dst_we, wr_strb, wr_row,
                     e.s, e.sz, e.d, e.wz, e.strb, e.row);
          end
        end
      end
      if (rst_n && done) done_cnt++;
    end
  end

  task automatic run_op(input string t, input int vlen, input logic [7:0] sm, input logic [7:0] dm,
                        input bit sz, input bit dz, input int ew, input bit poke);
    int ev, ns, nd, n, bpe, epr, lane, w, d0;
    int sl[$];
    int dl[$];
    tag = t;
    ev = (vlen > MAXVL) ? MAXVL : vlen;
    for (int i = 0; i < ev; i++) begin
      if (sz || sm[i]) sl.push_back(i);
      if (dz || dm[i]) dl.push_back(i);
    end
    ns = sl.size(); nd = dl.size();
    n = (ns < nd) ? ns : nd;
    bpe = 1 << ew;
    epr = NB / bpe;
    for (int k = 0; k < n; k++) begin
      item_t e;
      e.s = sl[k];
      e.sz = !sm[sl[k]];
      e.d = dl[k];
      e.wz = !dm[dl[k]];
      lane = e.d % epr;
      e.strb = 8'(((1 << bpe) - 1) << (lane * bpe));
      e.row = e.d / epr;
      q.push_back(e);
    end
    d0 = done_cnt;
    @(posedge clk); #1;
    vl = IDXW'(vlen); src_mask = sm; dst_mask = dm;
    src_zero_mode = sz; dst_zero_mode = dz; elem_w = 2'(ew);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin
      @(posedge clk); #1;
      vl = 4'd3; src_mask = ~sm; dst_mask = ~dm; src_zero_mode = ~sz; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    w = 0;
    while (done_cnt == d0 && w < 2000) begin
      @(posedge clk);
      w++;
    end
    @(negedge clk);
    checks++;
    if (w >= 2000 || q.size() != 0 || busy) begin
      fails++;
      $display("FAIL %s end: timeout=%0b left=%0d busy=%0b expected done with 0 left, idle",
               t, w >= 2000, q.size(), busy);
      q.delete();
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; vl = '0; src_mask = '0; dst_mask = '0;
    src_zero_mode = 1'b0; dst_zero_mode = 1'b0; elem_w = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (busy || step_valid || done || wr_strb != '0) begin
      fails++;
      $display("FAIL R1 reset: busy=%0b valid=%0b done=%0b strb=%h expected 0 0 0 00",
               busy, step_valid, done, wr_strb);
    end
    // R3 R5: both zeroing, identity walk, 8-bit elements
    run_op("R3/R5", 8, 8'b1011_0110, 8'b0101_1101, 1, 1, 0, 0);
    // R4: source compress into full destination
    run_op("R4", 8, 8'b1010_0101, 8'hFF, 0, 1, 1, 0);
    // R6: destination expand from full source
    run_op("R6", 8, 8'hFF, 8'b0110_1001, 1, 0, 2, 0);
    // R7: identical masks, different modes, indices drift
    run_op("R7", 8, 8'b1100_1010, 8'b1100_1010, 0, 1, 0, 0);
    run_op("R7", 8, 8'b0011_0101, 8'b0011_0101, 1, 0, 3, 0);
    // R7: compress then expand in one pass
    rdy_rand = 1'b1;
    run_op("R7", 8, 8'b1110_0100, 8'b0101_1010, 0, 0, 1, 0);
    // R8: irregular ready on zeroing walk, 16-bit elements
    run_op("R8", 7, 8'b0101_0101, 8'b1111_0000, 1, 1, 1, 0);
    // R2: restart attempt while busy
    run_op("R2", 8, 8'b1001_1011, 8'b1110_1101, 1, 1, 0, 1);
    rdy_rand = 1'b0;
    // R9: zero length, empty mask in skip mode, one side exhausts first
    run_op("R9", 0, 8'hFF, 8'hFF, 1, 1, 0, 0);
    run_op("R9", 8, 8'h00, 8'hFF, 0, 1, 0, 0);
    run_op("R9", 8, 8'hFF, 8'h00, 1, 0, 0, 0);
    run_op("R9", 5, 8'b1110_0000, 8'hFF, 0, 1, 0, 0);
    run_op("R9", 8, 8'b0000_0011, 8'hFF, 0, 1, 2, 0);
    // R10: oversize length clamps
    run_op("R10", 12, 8'hFF, 8'hFF, 1, 1, 0, 0);
    // R11: every element width, sparse destination
    run_op("R11", 8, 8'hFF, 8'hFF, 1, 1, 3, 0);
    run_op("R11", 8, 8'hFF, 8'b1000_0110, 1, 0, 2, 0);
    run_op("R11", 6, 8'b0011_1111, 8'hFF, 1, 1, 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule